// File: doc/BRIEF.md
# DMA Software Request Register Bank

This block holds the software side of a 16-line DMA request interface. Software can raise a "last burst" request and a "last single" request on any peripheral line. It does this by writing ones into one of two request registers. A raised bit stays pending until the DMA engine returns a one-cycle completion pulse for that line and request type. The bit then clears itself. Writing zero never cancels a pending request.

Each pending vector is ORed with the matching peripheral request vector before it goes to the DMA engine. The engine therefore sees one merged request per line and type. A small configuration register stores the byte-order selection for the second bus master port and drives it out as a level.

Access uses a plain register port. A write is captured on the rising clock edge. A read is combinational from the address and returns the live pending set. The register offsets are 0x0 for last-burst, 0x4 for last-single and 0x8 for configuration.

Top module: `dma_swreq_regs`

## Requirements
- R1: After synchronous active-low reset, both pending vectors and the byte-order bit are 0. The merged outputs then equal the peripheral inputs.
- R2: A write to offset 0x0 sets every last-burst pending bit whose data bit in [15:0] is 1. A read of 0x0 returns the pending set in bits [15:0].
- R3: A write to offset 0x4 sets every last-single pending bit whose data bit in [15:0] is 1. A read of 0x4 returns that pending set in bits [15:0].
- R4: A data bit of 0 in a request write leaves the matching pending bit unchanged. Software cannot clear a request.
- R5: A 1 on line i of a completion vector clears pending bit i of that type at the next edge. The other bits are kept. A pulse on a line that is not pending changes nothing.
- R6: When a software set and a completion pulse hit the same line and type in the same cycle, the bit ends up pending.
- R7: Each merged request output equals the pending vector ORed with the peripheral request vector, within the same cycle.
- R8: A last-burst completion pulse never changes the last-single pending vector, and a last-single completion pulse never changes the last-burst pending vector.
- R9: Reads of 0x0 and 0x4 return zero in bits [31:16]. Write data in bits [31:16] has no effect.
- R10: Bit 2 at offset 0x8 stores the byte order of master port 2 (0 = little-endian, 1 = big-endian). It drives `m2_big_endian`, and the other bits of this register read as zero.
- R11: A read of an unmapped offset returns zero, and a write to an unmapped offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, captured at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| periph_lburst_req | input | 16 | Peripheral last-burst requests |
| periph_lsingle_req | input | 16 | Peripheral last-single requests |
| burst_done | input | 16 | One-cycle last-burst completion pulses per line |
| single_done | input | 16 | One-cycle last-single completion pulses per line |
| dma_lburst_req | output | 16 | Merged last-burst requests to the DMA engine |
| dma_lsingle_req | output | 16 | Merged last-single requests to the DMA engine |
| m2_big_endian | output | 1 | Byte-order selection for master port 2 |

## Verification
Writes and completion pulses act at the one rising edge that samples them. Their effect is due in the first cycle after that edge. A peripheral request and a read address act with zero cycles of delay.

The bench drives every input one nanosecond after a rising edge. It holds a write or a pulse for exactly one edge, then queues the expected values. The monitor compares them at the following falling edge. Each comparison therefore sees the state after exactly one update, and same-cycle merges are checked within the cycle the input changed.

// File: rtl/dma_swreq_pkg.sv
// Package: shared sizes and register offsets of the DMA software request bank.
// Assumes a 32-bit data path and byte offsets decoded on a 4-bit address.
package dma_swreq_pkg;
    localparam int unsigned LINES  = 16;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned KINDS  = 2;   // 0 = last burst, 1 = last single
    localparam int unsigned ENDIAN_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LBURST  = 4'h0,
        OFS_LSINGLE = 4'h4,
        OFS_CFG     = 4'h8
    } reg_ofs_e;

    typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/swreq_pending.sv
// Module: one pending-request vector with self-clearing bits.
// Sets come from software, clears from per-line completion pulses; the set
// wins on a collision. The output is the pending set merged with peripheral
// requests. Assumes the completion pulses are synchronous to clk.
module swreq_pending #(
    parameter int unsigned LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [LINES-1:0] set_mask,
    input  logic [LINES-1:0] done_pulse,
    input  logic [LINES-1:0] periph_req,
    output logic [LINES-1:0] pending,
    output logic [LINES-1:0] req_out
);
    logic [LINES-1:0] set_bits;

    // Gate the software mask with the write select.
    always_comb begin
        set_bits = set_en ? set_mask : '0;
    end

    // Pending state: the clear is applied first, so a same-cycle set re-asserts the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            pending <= (pending & ~done_pulse) | set_bits;
        end
    end

    // Merge software and peripheral requests toward the engine.
    always_comb begin
        req_out = pending | periph_req;
    end
endmodule

// File: rtl/swreq_cfg.sv
// Module: configuration storage holding the master-2 byte-order bit.
// Assumes the address decode is done by the parent.
module swreq_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic big_endian
);
    // Store the byte-order selection on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_endian <= 1'b0;
        end else if (wr_en) begin
            big_endian <= wr_bit;
        end
    end
endmodule

// File: rtl/swreq_rdmux.sv
// Module: combinational read multiplexer for the register bank.
// Reserved and unmapped bits return zero.
module swreq_rdmux
    import dma_swreq_pkg::*;
#(
    parameter int unsigned LW = LINES,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned EB = ENDIAN_BIT
) (
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] burst_pend,
    input  logic [LW-1:0] single_pend,
    input  logic          big_endian,
    output logic [DW-1:0] rdata
);
    localparam int unsigned PAD_W = DW - LW;

    // Select the addressed register, zero-extended.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_LBURST:  rdata = {{PAD_W{1'b0}}, burst_pend};
            OFS_LSINGLE: rdata = {{PAD_W{1'b0}}, single_pend};
            OFS_CFG:     rdata[EB] = big_endian;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_swreq_regs.sv
// Module: top of the DMA software request register bank.
// Decodes register writes, keeps one pending vector per request type
// (last burst, last single), merges each with peripheral requests and
// holds the byte-order bit for master port 2.
// Assumes one-cycle completion pulses and a single-cycle write strobe.
module dma_swreq_regs
    import dma_swreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  periph_lburst_req,
    input  logic [LINES-1:0]  periph_lsingle_req,
    input  logic [LINES-1:0]  burst_done,
    input  logic [LINES-1:0]  single_done,
    output logic [LINES-1:0]  dma_lburst_req,
    output logic [LINES-1:0]  dma_lsingle_req,
    output logic              m2_big_endian
);
    logic [KINDS-1:0]            kind_wr;
    logic [KINDS-1:0][LINES-1:0] kind_done;
    logic [KINDS-1:0][LINES-1:0] kind_periph;
    logic [KINDS-1:0][LINES-1:0] kind_pend;
    logic [KINDS-1:0][LINES-1:0] kind_req;
    logic                        cfg_wr;
    logic [LINES-1:0]            pend_lburst;
    logic [LINES-1:0]            pend_lsingle;

    // Address decode for the write strobes.
    always_comb begin
        kind_wr[0] = bus_wr && (bus_addr == OFS_LBURST);
        kind_wr[1] = bus_wr && (bus_addr == OFS_LSINGLE);
        cfg_wr     = bus_wr && (bus_addr == OFS_CFG);
    end

    // Route per-kind inputs into arrays.
    always_comb begin
        kind_done[0]   = burst_done;
        kind_done[1]   = single_done;
        kind_periph[0] = periph_lburst_req;
        kind_periph[1] = periph_lsingle_req;
    end

    for (genvar k = 0; k < KINDS; k++) begin : g_kind
        swreq_pending #(.LINES(LINES)) u_pend (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_en     (kind_wr[k]),
            .set_mask   (bus_wdata[LINES-1:0]),
            .done_pulse (kind_done[k]),
            .periph_req (kind_periph[k]),
            .pending    (kind_pend[k]),
            .req_out    (kind_req[k])
        );
    end

    // Break the arrays back out into named outputs.
    always_comb begin
        pend_lburst     = kind_pend[0];
        pend_lsingle    = kind_pend[1];
        dma_lburst_req  = kind_req[0];
        dma_lsingle_req = kind_req[1];
    end

    swreq_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .wr_bit     (bus_wdata[ENDIAN_BIT]),
        .big_endian (m2_big_endian)
    );

    swreq_rdmux u_rd (
        .addr        (bus_addr),
        .burst_pend  (pend_lburst),
        .single_pend (pend_lsingle),
        .big_endian  (m2_big_endian),
        .rdata       (bus_rdata)
    );
endmodule

// File: rtl/dma_swreq_regs_chk.sv
// Checker: temporal properties of the DMA software request register bank,
// bound to the top module.
module dma_swreq_regs_chk
    import dma_swreq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LINES-1:0]  periph_lburst_req,
    input logic [LINES-1:0]  burst_done,
    input logic [LINES-1:0]  single_done,
    input logic [LINES-1:0]  dma_lburst_req,
    input logic              m2_big_endian,
    input logic [LINES-1:0]  pend_lburst,
    input logic [LINES-1:0]  pend_lsingle
);
    logic             wr_b;
    logic             wr_s;
    logic [LINES-1:0] wmask;

    always_comb begin
        wr_b  = bus_wr && (bus_addr == OFS_LBURST);
        wr_s  = bus_wr && (bus_addr == OFS_LSINGLE);
        wmask = bus_wdata[LINES-1:0];
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_lburst == '0 && pend_lsingle == '0 && !m2_big_endian));

    assert_burst_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> ((pend_lburst & $past(wmask)) == $past(wmask)));

    assert_single_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_s |=> ((pend_lsingle & $past(wmask)) == $past(wmask)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && burst_done == '0) |=> $stable(pend_lburst));

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_b |=> ((pend_lburst & $past(burst_done)) == '0));

    assert_kind_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && single_done == '0 && burst_done != '0) |=> $stable(pend_lsingle));

    // R7: every raised peripheral line shows up on the merged output.
    always_comb begin
        if (rst_n) begin
            assert_merge_R7: assert ((dma_lburst_req & periph_lburst_req) == periph_lburst_req);
        end
    end

    // R9 / R10: reserved read bits are zero.
    always_comb begin
        if (rst_n && (bus_addr == OFS_LBURST || bus_addr == OFS_LSINGLE)) begin
            assert_rsvd_zero_R9: assert (bus_rdata[DATA_W-1:LINES] == '0);
        end
        if (rst_n && bus_addr == OFS_CFG) begin
            assert_cfg_read_R10: assert (bus_rdata == (DATA_W'(m2_big_endian) << ENDIAN_BIT));
        end
    end
endmodule

bind dma_swreq_regs dma_swreq_regs_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_addr          (bus_addr),
    .bus_wr            (bus_wr),
    .bus_wdata         (bus_wdata),
    .bus_rdata         (bus_rdata),
    .periph_lburst_req (periph_lburst_req),
    .burst_done        (burst_done),
    .single_done       (single_done),
    .dma_lburst_req    (dma_lburst_req),
    .m2_big_endian     (m2_big_endian),
    .pend_lburst       (pend_lburst),
    .pend_lsingle      (pend_lsingle)
);

// File: tb/dma_swreq_regs_bench.sv
// Bench: scoreboard driven; tasks queue expectations, a monitor compares them
// at the falling edge after inputs settle.
module dma_swreq_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] periph_lburst_req = '0;
    logic [15:0] periph_lsingle_req = '0;
    logic [15:0] burst_done = '0;
    logic [15:0] single_done = '0;
    logic [15:0] dma_lburst_req;
    logic [15:0] dma_lsingle_req;
    logic        m2_big_endian;

    typedef enum logic [1:0] {OBS_RDATA, OBS_BURST, OBS_SINGLE, OBS_M2} obs_e;
    typedef struct {
        obs_e        what;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done_flag = 1'b0;

    always #4 clk = ~clk;

    dma_swreq_regs u_dma_swreq_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_lburst_req(periph_lburst_req), .periph_lsingle_req(periph_lsingle_req),
        .burst_done(burst_done), .single_done(single_done),
        .dma_lburst_req(dma_lburst_req), .dma_lsingle_req(dma_lsingle_req),
        .m2_big_endian(m2_big_endian)
    );

    // Monitor: pop every queued expectation and compare with the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.what)
                OBS_RDATA:  act = bus_rdata;
                OBS_BURST:  act = {16'h0, dma_lburst_req};
                OBS_SINGLE: act = {16'h0, dma_lsingle_req};
                default:    act = {31'h0, m2_big_endian};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s: %s actual=%h expected=%h", it.req, it.what.name(), act, it.exp);
            end
        end
    end

    task automatic expect_item(input obs_e w, input logic [31:0] e, input string r);
        sb.push_back('{what: w, exp: e, req: r});
    endtask

    task automatic expect_read(input logic [3:0] a, input logic [31:0] e, input string r);
        bus_addr = a;
        expect_item(OBS_RDATA, e, r);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d,
                            input logic [15:0] bd, input logic [15:0] sd);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        burst_done = bd; single_done = sd;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0; burst_done = '0; single_done = '0;
    endtask

    task automatic pulse(input logic [15:0] bd, input logic [15:0] sd);
        @(posedge clk); #1;
        burst_done = bd; single_done = sd;
        @(posedge clk); #1;
        burst_done = '0; single_done = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_read(4'h0, 32'h0, "R1");
        expect_item(OBS_BURST, 32'h0, "R1");
        expect_item(OBS_SINGLE, 32'h0, "R1");
        expect_item(OBS_M2, 32'h0, "R1");
        settle();
        rst_n = 1'b1;

        // R2 and R9: set burst lines; upper write bits ignored.
        do_write(4'h0, 32'hFFFF_00A5, 16'h0, 16'h0);
        expect_read(4'h0, 32'h0000_00A5, "R2/R9");
        expect_item(OBS_BURST, 32'h00A5, "R2");
        settle();

        // R3: set single lines.
        do_write(4'h4, 32'h0000_8001, 16'h0, 16'h0);
        expect_read(4'h4, 32'h0000_8001, "R3");
        expect_item(OBS_SINGLE, 32'h8001, "R3");
        expect_item(OBS_BURST, 32'h00A5, "R3");
        settle();

        // R4: writing zeros cannot cancel.
        do_write(4'h0, 32'h0, 16'h0, 16'h0);
        expect_read(4'h0, 32'h0000_00A5, "R4");
        settle();

        // R7: peripheral requests merge in the same cycle.
        @(posedge clk); #1;
        periph_lburst_req = 16'h0F00;
        periph_lsingle_req = 16'h0010;
        expect_item(OBS_BURST, 32'h0FA5, "R7");
        expect_item(OBS_SINGLE, 32'h8011, "R7");
        expect_read(4'h0, 32'h0000_00A5, "R7");
        settle();
        periph_lburst_req = '0;
        periph_lsingle_req = '0;

        // R5: completion clears only the pulsed lines.
        pulse(16'h0005, 16'h0);
        expect_read(4'h0, 32'h0000_00A0, "R5");
        settle();

        // R8 and R5: burst pulse on line 15 leaves single line 15 and idle burst line alone.
        pulse(16'h8000, 16'h0);
        expect_read(4'h4, 32'h0000_8001, "R8");
        expect_item(OBS_BURST, 32'h00A0, "R5");
        settle();

        // R6: set and completion on the same line and cycle.
        do_write(4'h0, 32'h0000_0020, 16'h00A0, 16'h0);
        expect_read(4'h0, 32'h0000_0020, "R6");
        settle();

        // R5: single completion empties the single register.
        pulse(16'h0, 16'h8001);
        expect_read(4'h4, 32'h0, "R5");
        expect_item(OBS_BURST, 32'h0020, "R8");
        settle();

        // R10: byte-order bit.
        do_write(4'h8, 32'hFFFF_FFFF, 16'h0, 16'h0);
        expect_read(4'h8, 32'h0000_0004, "R10");
        expect_item(OBS_M2, 32'h1, "R10");
        settle();
        do_write(4'h8, 32'h0, 16'h0, 16'h0);
        expect_item(OBS_M2, 32'h0, "R10");
        settle();

        // R11: unmapped offset.
        do_write(4'hC, 32'hFFFF_FFFF, 16'h0, 16'h0);
        expect_read(4'hC, 32'h0, "R11");
        settle();
        expect_read(4'h0, 32'h0000_0020, "R11");
        settle();
        expect_read(4'h4, 32'h0, "R11");
        expect_item(OBS_M2, 32'h0, "R11");
        settle();

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 20000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule